// File: doc/BRIEF.md
# Power Domain Switch Controller

This block turns power on and off for a small set of independent domains under control of a simple register port. Software writes one request bit per domain into a control word. A set bit asks the domain to turn off and a clear bit asks it to turn on. Each domain then runs a timed transition and reports its settled state in a status word. The switch itself is modelled as a counted delay, and each domain has one switch-enable output.

Each domain takes its transition lengths from one of two programmable count pairs. The core pair serves most domains and the GPU pair serves the rest. A pair holds separate counts for turning off and for turning on. A domain's status bit need not sit at the same bit position as its control bit, so each domain has its own control and status positions, both set by parameters. If a request reverses while a transition is in flight, the count restarts in the new direction.

Top module: `pwr_switch_ctrl`

## Requirements
- R1: After reset every domain is on. Every `pwr_en` bit is 1, the control word (byte address 0x08) and the status word (0x0C) read 0, and all four count registers read 24.
- R2: Writing the control word with a domain's control bit at 1 drives that domain's `pwr_en` to 0 on the clock edge after the write edge. Writing the bit at 0 drives it back to 1 on that edge. The default control bits are 7, 14, 8 and 9 for domains 0 to 3.
- R3: A power-off request sets the domain's status bit to 1, meaning off. The bit changes exactly D+1 edges after the write edge, where D is the off count of the domain's pair: core off count at 0x34, GPU off count at 0x3C. Domain 3 uses the GPU pair and the others use the core pair.
- R4: A power-on request clears the status bit to 0, meaning on. The bit changes exactly U+1 edges after the write edge, where U is the on count at pair base+4 (core 0x38, GPU 0x40).
- R5: Status positions come from a separate map. The defaults are bits 7, 10, 8 and 9, so domain 1 is controlled by bit 14 but reports on bit 10.
- R6: A request that reverses a transition in progress restarts the count in the new direction. A domain sent off and then back on before its off count elapses never shows status 1.
- R7: A count of 0 acts as a count of 1.
- R8: Count registers keep the low 16 bits of a write. Unused bits of every register read 0. Writes to the status word have no effect.
- R9: A transition uses the count that was in force when it started. Rewriting the count during the transition does not change its length.
- R10: A read issued with `rd_en` on one edge returns its data on `rdata` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Word write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pwr_en | output | 4 | Per-domain switch enable, 1 = supply connected |

## Verification
The checks take reset to be held high from time zero for at least one edge. They also take the control register to be the only thing that moves the requests, so `pwr_en` can be predicted from the request of the cycle before. Status may only turn off while the enable is already low and only turn on while it is high, which assumes every count is at least one cycle long. The stimulus holds reset from the start and drives every request through register writes. Counts of 0 are applied only where the design is required to stretch them to one cycle.

// File: rtl/pwr_sw_pkg.sv
package pwr_sw_pkg;

  typedef enum logic [1:0] {
    DOM_ON        = 2'd0,
    DOM_GOING_OFF = 2'd1,
    DOM_OFF       = 2'd2,
    DOM_GOING_ON  = 2'd3
  } dom_state_e;

  localparam logic [7:0] OFS_CTRL    = 8'h08;
  localparam logic [7:0] OFS_STAT    = 8'h0C;
  localparam logic [7:0] OFS_CORE_DN = 8'h34;
  localparam logic [7:0] OFS_CORE_UP = 8'h38;
  localparam logic [7:0] OFS_GPU_DN  = 8'h3C;
  localparam logic [7:0] OFS_GPU_UP  = 8'h40;

endpackage

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
  import pwr_sw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_off,
  input  logic [CNT_W-1:0] dn_cnt,
  input  logic [CNT_W-1:0] up_cnt,
  output logic             en_q,
  output logic             off_q
);

  dom_state_e       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             last_tick;

  assign last_tick = (cnt_q <= CNT_W'(1));

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    unique case (st_q)
      DOM_ON: begin
        if (req_off) begin
          st_n  = DOM_GOING_OFF;
          cnt_n = dn_cnt;
        end
      end
      DOM_GOING_OFF: begin
        if (!req_off) begin
          st_n  = DOM_GOING_ON;
          cnt_n = up_cnt;
        end else if (last_tick) begin
          st_n = DOM_OFF;
        end else begin
          cnt_n = cnt_q - CNT_W'(1);
        end
      end
      DOM_OFF: begin
        if (!req_off) begin
          st_n  = DOM_GOING_ON;
          cnt_n = up_cnt;
        end
      end
      DOM_GOING_ON: begin
        if (req_off) begin
          st_n  = DOM_GOING_OFF;
          cnt_n = dn_cnt;
        end else if (last_tick) begin
          st_n = DOM_ON;
        end else begin
          cnt_n = cnt_q - CNT_W'(1);
        end
      end
      default: st_n = DOM_ON;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= DOM_ON;
      cnt_q <= '0;
      en_q  <= 1'b1;
      off_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      en_q  <= (st_n == DOM_ON) || (st_n == DOM_GOING_ON);
      if (st_n == DOM_OFF)     off_q <= 1'b1;
      else if (st_n == DOM_ON) off_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pwr_sw_regs.sv
module pwr_sw_regs
  import pwr_sw_pkg::*;
#(
  parameter int                      N_DOM    = 4,
  parameter int                      ADDR_W   = 8,
  parameter int                      DATA_W   = 32,
  parameter int                      CNT_W    = 16,
  parameter int                      POS_W    = 5,
  parameter int                      DEF_CNT  = 24,
  parameter logic [N_DOM*POS_W-1:0]  CTRL_POS = '0,
  parameter logic [N_DOM*POS_W-1:0]  STAT_POS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_DOM-1:0]  dom_off,
  output logic [DATA_W-1:0] rdata,
  output logic [N_DOM-1:0]  dom_req,
  output logic [CNT_W-1:0]  core_dn,
  output logic [CNT_W-1:0]  core_up,
  output logic [CNT_W-1:0]  gpu_dn,
  output logic [CNT_W-1:0]  gpu_up
);

  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(DEF_CNT);

  logic [DATA_W-1:0] ctrl_view, stat_view, rd_n;

  always_comb begin
    ctrl_view = '0;
    stat_view = '0;
    for (int i = 0; i < N_DOM; i++) begin
      ctrl_view[CTRL_POS[i*POS_W +: POS_W]] = dom_req[i];
      stat_view[STAT_POS[i*POS_W +: POS_W]] = dom_off[i];
    end
  end

  always_comb begin
    rd_n = '0;
    if      (addr == ADDR_W'(OFS_CTRL))    rd_n = ctrl_view;
    else if (addr == ADDR_W'(OFS_STAT))    rd_n = stat_view;
    else if (addr == ADDR_W'(OFS_CORE_DN)) rd_n = DATA_W'(core_dn);
    else if (addr == ADDR_W'(OFS_CORE_UP)) rd_n = DATA_W'(core_up);
    else if (addr == ADDR_W'(OFS_GPU_DN))  rd_n = DATA_W'(gpu_dn);
    else if (addr == ADDR_W'(OFS_GPU_UP))  rd_n = DATA_W'(gpu_up);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dom_req <= '0;
      core_dn <= CNT_RST;
      core_up <= CNT_RST;
      gpu_dn  <= CNT_RST;
      gpu_up  <= CNT_RST;
      rdata   <= '0;
    end else begin
      if (wr_en) begin
        if (addr == ADDR_W'(OFS_CTRL)) begin
          for (int i = 0; i < N_DOM; i++)
            dom_req[i] <= wdata[CTRL_POS[i*POS_W +: POS_W]];
        end
        if (addr == ADDR_W'(OFS_CORE_DN)) core_dn <= wdata[CNT_W-1:0];
        if (addr == ADDR_W'(OFS_CORE_UP)) core_up <= wdata[CNT_W-1:0];
        if (addr == ADDR_W'(OFS_GPU_DN))  gpu_dn  <= wdata[CNT_W-1:0];
        if (addr == ADDR_W'(OFS_GPU_UP))  gpu_up  <= wdata[CNT_W-1:0];
      end
      if (rd_en) rdata <= rd_n;
    end
  end

endmodule

// File: rtl/pwr_switch_ctrl.sv
module pwr_switch_ctrl
  import pwr_sw_pkg::*;
#(
  parameter int                     N_DOM    = 4,
  parameter int                     ADDR_W   = 8,
  parameter int                     DATA_W   = 32,
  parameter int                     CNT_W    = 16,
  parameter int                     POS_W    = 5,
  parameter int                     DEF_CNT  = 24,
  parameter logic [N_DOM*POS_W-1:0] CTRL_POS = {5'd9, 5'd8, 5'd14, 5'd7},
  parameter logic [N_DOM*POS_W-1:0] STAT_POS = {5'd9, 5'd8, 5'd10, 5'd7},
  parameter logic [N_DOM-1:0]       GPU_SEL  = 4'b1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N_DOM-1:0]  pwr_en
);

  logic [N_DOM-1:0] dom_req;
  logic [N_DOM-1:0] dom_off;
  logic [CNT_W-1:0] core_dn, core_up, gpu_dn, gpu_up;

  pwr_sw_regs #(
    .N_DOM(N_DOM), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .POS_W(POS_W), .DEF_CNT(DEF_CNT), .CTRL_POS(CTRL_POS), .STAT_POS(STAT_POS)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .dom_off(dom_off), .rdata(rdata), .dom_req(dom_req),
    .core_dn(core_dn), .core_up(core_up), .gpu_dn(gpu_dn), .gpu_up(gpu_up)
  );

  for (genvar g = 0; g < N_DOM; g++) begin : g_dom
    logic [CNT_W-1:0] dn_sel, up_sel;
    if (GPU_SEL[g]) begin : g_gpu
      assign dn_sel = gpu_dn;
      assign up_sel = gpu_up;
    end else begin : g_core
      assign dn_sel = core_dn;
      assign up_sel = core_up;
    end
    pwr_dom_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst(rst), .req_off(dom_req[g]),
      .dn_cnt(dn_sel), .up_cnt(up_sel),
      .en_q(pwr_en[g]), .off_q(dom_off[g])
    );
  end

endmodule

// File: rtl/pwr_switch_ctrl_chk.sv
module pwr_switch_ctrl_chk #(
  parameter int N_DOM = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [N_DOM-1:0] dom_req,
  input logic [N_DOM-1:0] dom_off,
  input logic [N_DOM-1:0] pwr_en
);

  AST_RESET_ALL_ON: assert property (@(posedge clk)
    rst |=> (dom_off == '0 && pwr_en == '1)); // R1

  AST_EN_TRACKS_REQ: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (pwr_en == ~$past(dom_req))); // R2

  AST_OFF_NEEDS_EN_LOW: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((dom_off & ~$past(dom_off) & $past(pwr_en)) == '0)); // R3

  AST_ON_NEEDS_EN_HIGH: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((~dom_off & $past(dom_off) & ~$past(pwr_en)) == '0)); // R4

endmodule

bind pwr_switch_ctrl pwr_switch_ctrl_chk #(.N_DOM(N_DOM)) u_chk (
  .clk(clk), .rst(rst), .dom_req(dom_req), .dom_off(dom_off), .pwr_en(pwr_en)
);

// File: tb/pwr_switch_ctrl_tb.sv
module pwr_switch_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwr_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_switch_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwr_en(pwr_en)
  );

  function automatic int cpos(input int d);
    case (d) 0: return 7; 1: return 14; 2: return 8; default: return 9; endcase
  endfunction
  function automatic int spos(input int d);
    case (d) 0: return 7; 1: return 10; 2: return 8; default: return 9; endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk); #1 rd_en = 1'b0; d = rdata;
  endtask

  // Write control word, then poll status; lat = edge of status change after write edge.
  task automatic xfer(input logic [31:0] cw, input int d, input bit exp_off,
                      input string tag, input int exp_lat);
    int lat;
    lat = -1;
    @(negedge clk); wr_en = 1'b1; addr = 8'h08; wdata = cw;
    @(posedge clk); #1 wr_en = 1'b0; rd_en = 1'b1; addr = 8'h0C;
    chk(pwr_en[d] == exp_off, "R2 enable holds on write edge", pwr_en[d], exp_off);
    for (int j = 1; j <= 80; j++) begin
      @(posedge clk); #1;
      if (j == 1) chk(pwr_en[d] == !exp_off, "R2 enable follows request", pwr_en[d], !exp_off);
      if (lat < 0 && rdata[spos(d)] == exp_off) lat = j - 1;
    end
    rd_en = 1'b0;
    chk(lat == exp_lat, tag, lat, exp_lat);
  endtask

  initial begin
    logic [31:0] v;
    int dn_a, up_a, neff;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk(pwr_en == 4'hF, "R1 pwr_en", pwr_en, 4'hF);
    rd(8'h08, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(8'h0C, v); chk(v == 0, "R1 status", v, 0);
    rd(8'h34, v); chk(v == 24, "R1 core dn R10", v, 24);
    rd(8'h38, v); chk(v == 24, "R1 core up", v, 24);
    rd(8'h3C, v); chk(v == 24, "R1 gpu dn", v, 24);
    rd(8'h40, v); chk(v == 24, "R1 gpu up", v, 24);

    // R8 count width, unused bits, status write ignored
    wr(8'h34, 32'hFFFF_FFFF);
    rd(8'h34, v); chk(v == 32'h0000_FFFF, "R8 count width", v, 32'hFFFF);
    wr(8'h34, 2); wr(8'h38, 2); wr(8'h3C, 2); wr(8'h40, 2);
    wr(8'h08, 32'hFFFF_FFFF);
    repeat (10) @(posedge clk);
    rd(8'h08, v); chk(v == 32'h0000_4380, "R8 ctrl unused bits", v, 32'h4380);
    rd(8'h0C, v); chk(v == 32'h0000_0780, "R3 R5 all off", v, 32'h780);
    wr(8'h0C, 32'h0);
    rd(8'h0C, v); chk(v == 32'h0000_0780, "R8 status write ignored", v, 32'h780);
    wr(8'h08, 32'h0);
    repeat (10) @(posedge clk);
    rd(8'h0C, v); chk(v == 0, "R4 all on", v, 0);

    // Sweep domains and counts (R3 R4 R5 R7)
    for (int d = 0; d < 4; d++) begin
      for (int k = 0; k < 4; k++) begin
        int n;
        n = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 3 : 7;
        dn_a = (d == 3) ? 8'h3C : 8'h34;
        up_a = (d == 3) ? 8'h40 : 8'h38;
        wr(8'(dn_a), n); wr(8'(up_a), n + 2);
        neff = (n == 0) ? 1 : n;
        xfer(32'(1) << cpos(d), d, 1'b1, (n == 0) ? "R7 R3 R5 off latency" : "R3 R5 off latency", neff + 1);
        xfer(32'h0, d, 1'b0, "R4 on latency", n + 3);
      end
    end

    // R6 reversal: off count 8, on count 3; reverse at edge 3
    wr(8'h34, 8); wr(8'h38, 3);
    wr(8'h08, 32'h80);
    repeat (2) @(posedge clk);
    wr(8'h08, 32'h0);
    begin
      bit seen;
      seen = 0;
      @(negedge clk); rd_en = 1'b1; addr = 8'h0C;
      for (int j = 0; j < 20; j++) begin
        @(posedge clk); #1;
        if (rdata[7]) seen = 1;
      end
      rd_en = 1'b0;
      chk(!seen, "R6 reversed request never reports off", seen, 0);
      chk(pwr_en[0] == 1'b1, "R6 enable restored", pwr_en[0], 1);
    end
    xfer(32'h80, 0, 1'b1, "R6 off after reversal", 9);
    xfer(32'h0, 0, 1'b0, "R6 on after reversal", 4);

    // R9 count captured at start (GPU domain 3, off count 12 rewritten to 3)
    wr(8'h3C, 12);
    wr(8'h08, 32'h200);
    wr(8'h3C, 3);
    begin
      int lat;
      lat = -1;
      @(negedge clk); rd_en = 1'b1; addr = 8'h0C;
      for (int j = 2; j <= 40; j++) begin
        @(posedge clk); #1;
        if (lat < 0 && rdata[9]) lat = j - 1;
      end
      rd_en = 1'b0;
      chk(lat == 13, "R9 in-flight count unchanged", lat, 13);
    end
    wr(8'h08, 32'h0);
    repeat (10) @(posedge clk);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule